// File: doc/BRIEF.md
# Age-Ordered Transaction Conflict Arbiter

This block decides how an eager-conflict transactional memory reacts when a coherence request meets a block already held by another running transaction. For each conflict it gets the kind of conflict as seen by the requestor, the age stamps and processor numbers of both transactions, an external possible-deadlock hint and a two-bit policy select. It answers with exactly one of three strobes: the requestor stalls and retries, the requestor aborts itself, or the responder's transaction is told to abort.

Three resolution policies are available. The baseline policy always stalls unless a possible deadlock exists, in which case the requestor gives up. The age policy lets an older requestor abort a younger responder, and makes a younger requestor wait. The mixed policy works like the baseline policy, with one exception: when an older transaction wants to write a block that a younger transaction has read, the reader is aborted. To detect possible deadlock the block keeps one flag per processor. The flag records that the transaction on that processor has made an older transaction wait. The flag is cleared when the transaction ends or is aborted by a decision. The age stamps come from outside. They are expected to be fixed at the first start of a transaction and kept across retries.

Top module: `txn_conflict_arbiter`

## Requirements
- R1: While reset is held, and on the first sampling after reset, all three strobes are low and every per-processor wait flag is clear.
- R2: Conflict kind 2'b00 means no conflict. It produces no strobe and changes no wait flag.
- R3: For every conflict kind 2'b01 (requestor writes a block the responder read), 2'b10 (requestor reads a block the responder wrote) or 2'b11 (both write), exactly one strobe is high in the cycle after the request is presented, and for one cycle only.
- R4: The requestor is older when its stamp is numerically lower. When the stamps are equal, the lower processor number is older.
- R5: Policy 2'b00 (baseline) stalls the requestor unless a possible deadlock exists, and then aborts the requestor. It never aborts the responder.
- R6: A possible deadlock exists when the requestor is younger than the responder and the requestor's wait flag is set. The responder's wait flag is set whenever a stall is decided for a requestor that is older than that responder.
- R7: The external possible-deadlock hint counts as a possible deadlock under the baseline, mixed and spare policies. The age policy ignores it.
- R8: Policy 2'b01 (age) aborts the responder when the requestor is older, and otherwise stalls the requestor. It never aborts the requestor.
- R9: Policy 2'b10 (mixed) aborts the responder for kind 2'b01 with an older requestor. In every other case it acts as the baseline policy.
- R10: Policy 2'b11 acts exactly as the baseline policy.
- R11: A wait flag is cleared when its processor reports the end of its transaction, when a requestor-abort is decided for it as requestor, or when a responder-abort is decided for it as responder. When an end report and a flag set hit the same processor in the same cycle, the end report wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfl_kind_i | input | 2 | Conflict kind: 00 none, 01 requestor-write after responder-read, 10 requestor-read after responder-write, 11 write/write |
| policy_i | input | 2 | Resolution policy: 00 baseline, 01 age, 10 mixed, 11 baseline |
| req_id_i | input | ID_W | Requestor processor number |
| rsp_id_i | input | ID_W | Responder processor number (differs from requestor) |
| req_stamp_i | input | TS_W | Requestor transaction age stamp |
| rsp_stamp_i | input | TS_W | Responder transaction age stamp |
| dl_hint_i | input | 1 | External possible-deadlock hint |
| txn_end_i | input | 1 | A transaction has finished (commit or abort) |
| txn_end_id_i | input | ID_W | Processor whose transaction finished |
| stall_o | output | 1 | Requestor must stall and retry |
| abort_req_o | output | 1 | Requestor must abort |
| abort_rsp_o | output | 1 | Responder must abort |

## Verification
The bench uses random vectors with small stamp ranges, so ties are common and the processor-number tie-break is exercised. All four policy codes are mixed with random conflict kinds, including no conflict, and with random deadlock hints and end reports. A reference model with its own wait flags predicts each answer. This separates a wrong age comparison from a wrong policy table. Directed sequences build a real two-transaction deadlock under the baseline policy and show that the hint has no effect under the age policy. They also check that an end report and the mixed-policy read/write exception clear a flag, which a later request then shows.

// File: rtl/txres_pkg.sv
package txres_pkg;

  typedef enum logic [1:0] {
    KIND_NONE = 2'b00,
    KIND_RW   = 2'b01,
    KIND_WR   = 2'b10,
    KIND_WW   = 2'b11
  } cfl_kind_e;

  typedef enum logic [1:0] {
    POL_BASE   = 2'b00,
    POL_AGE    = 2'b01,
    POL_MIXED  = 2'b10,
    POL_SPARE  = 2'b11
  } policy_e;

  typedef enum logic [1:0] {
    ACT_NONE      = 2'b00,
    ACT_STALL     = 2'b01,
    ACT_ABORT_REQ = 2'b10,
    ACT_ABORT_RSP = 2'b11
  } action_e;

endpackage

// File: rtl/txres_age_cmp.sv
module txres_age_cmp #(
  parameter int TS_W = 16,
  parameter int ID_W = 3
) (
  input  logic [TS_W-1:0] req_stamp_i,
  input  logic [TS_W-1:0] rsp_stamp_i,
  input  logic [ID_W-1:0] req_id_i,
  input  logic [ID_W-1:0] rsp_id_i,
  output logic            req_older_o
);

  logic stamp_lt;
  logic stamp_eq;
  logic id_lt;

  always_comb begin
    stamp_lt    = (req_stamp_i < rsp_stamp_i);
    stamp_eq    = (req_stamp_i == rsp_stamp_i);
    id_lt       = (req_id_i < rsp_id_i);
    req_older_o = stamp_lt | (stamp_eq & id_lt);
  end

endmodule

// File: rtl/txres_policy.sv
module txres_policy
  import txres_pkg::*;
(
  input  cfl_kind_e kind_i,
  input  policy_e   policy_i,
  input  logic      req_older_i,
  input  logic      dl_possible_i,
  output action_e   act_o
);

  action_e base_act;

  always_comb begin
    base_act = dl_possible_i ? ACT_ABORT_REQ : ACT_STALL;
    act_o    = ACT_NONE;
    if (kind_i != KIND_NONE) begin
      unique case (policy_i)
        POL_AGE:   act_o = req_older_i ? ACT_ABORT_RSP : ACT_STALL;
        POL_MIXED: act_o = ((kind_i == KIND_RW) && req_older_i) ? ACT_ABORT_RSP : base_act;
        default:   act_o = base_act;
      endcase
    end
  end

endmodule

// File: rtl/txres_wait_track.sv
module txres_wait_track
  import txres_pkg::*;
#(
  parameter int NPROC = 8,
  parameter int ID_W  = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  action_e         act_i,
  input  logic            req_older_i,
  input  logic [ID_W-1:0] req_id_i,
  input  logic [ID_W-1:0] rsp_id_i,
  input  logic            end_vld_i,
  input  logic [ID_W-1:0] end_id_i,
  output logic            req_flag_o
);

  logic [NPROC-1:0] flag_vec;

  for (genvar g = 0; g < NPROC; g++) begin : g_entry
    logic flag_q;
    logic flag_d;
    logic set_hit;
    logic clr_hit;
    logic en;

    always_comb begin
      set_hit = (act_i == ACT_STALL) && req_older_i && (rsp_id_i == ID_W'(g));
      clr_hit = ((act_i == ACT_ABORT_REQ) && (req_id_i == ID_W'(g))) ||
                ((act_i == ACT_ABORT_RSP) && (rsp_id_i == ID_W'(g))) ||
                (end_vld_i && (end_id_i == ID_W'(g)));
      en      = set_hit | clr_hit;
      flag_d  = clr_hit ? 1'b0 : 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  flag_q <= 1'b0;
      else if (en) flag_q <= flag_d;
    end

    assign flag_vec[g] = flag_q;

    // R11: an end report always leaves the flag clear
    p_end_clears_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (end_vld_i && end_id_i == ID_W'(g)) |=> !flag_q);
  end

  assign req_flag_o = flag_vec[req_id_i];

endmodule

// File: rtl/txn_conflict_arbiter.sv
module txn_conflict_arbiter
  import txres_pkg::*;
#(
  parameter int NPROC = 8,
  parameter int TS_W  = 16,
  localparam int ID_W = (NPROC > 1) ? $clog2(NPROC) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [1:0]      cfl_kind_i,
  input  logic [1:0]      policy_i,
  input  logic [ID_W-1:0] req_id_i,
  input  logic [ID_W-1:0] rsp_id_i,
  input  logic [TS_W-1:0] req_stamp_i,
  input  logic [TS_W-1:0] rsp_stamp_i,
  input  logic            dl_hint_i,
  input  logic            txn_end_i,
  input  logic [ID_W-1:0] txn_end_id_i,
  output logic            stall_o,
  output logic            abort_req_o,
  output logic            abort_rsp_o
);

  cfl_kind_e kind;
  policy_e   pol;
  logic      req_older;
  logic      req_flag;
  logic      dl_possible;
  action_e   act;

  logic      stall_d, abort_req_d, abort_rsp_d;
  logic      stall_q, abort_req_q, abort_rsp_q;

  assign kind = cfl_kind_e'(cfl_kind_i);
  assign pol  = policy_e'(policy_i);

  txres_age_cmp #(.TS_W(TS_W), .ID_W(ID_W)) u_age (
    .req_stamp_i (req_stamp_i),
    .rsp_stamp_i (rsp_stamp_i),
    .req_id_i    (req_id_i),
    .rsp_id_i    (rsp_id_i),
    .req_older_o (req_older)
  );

  txres_wait_track #(.NPROC(NPROC), .ID_W(ID_W)) u_track (
    .clk         (clk),
    .rst_n       (rst_n),
    .act_i       (act),
    .req_older_i (req_older),
    .req_id_i    (req_id_i),
    .rsp_id_i    (rsp_id_i),
    .end_vld_i   (txn_end_i),
    .end_id_i    (txn_end_id_i),
    .req_flag_o  (req_flag)
  );

  assign dl_possible = dl_hint_i | (~req_older & req_flag);

  txres_policy u_pol (
    .kind_i        (kind),
    .policy_i      (pol),
    .req_older_i   (req_older),
    .dl_possible_i (dl_possible),
    .act_o         (act)
  );

  always_comb begin
    stall_d     = (act == ACT_STALL);
    abort_req_d = (act == ACT_ABORT_REQ);
    abort_rsp_d = (act == ACT_ABORT_RSP);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stall_q     <= 1'b0;
      abort_req_q <= 1'b0;
      abort_rsp_q <= 1'b0;
    end else begin
      stall_q     <= stall_d;
      abort_req_q <= abort_req_d;
      abort_rsp_q <= abort_rsp_d;
    end
  end

  assign stall_o     = stall_q;
  assign abort_req_o = abort_req_q;
  assign abort_rsp_o = abort_rsp_q;

  // R3: never more than one strobe
  p_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({stall_o, abort_req_o, abort_rsp_o}));

  // R3: a conflict yields exactly one strobe on the next cycle
  p_one_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfl_kind_i != 2'b00) |=> ($countones({stall_o, abort_req_o, abort_rsp_o}) == 1));

  // R2: no conflict, no strobe
  p_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfl_kind_i == 2'b00) |=> !(stall_o | abort_req_o | abort_rsp_o));

  // R5: baseline never aborts the responder
  p_base_keeps_rsp_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cfl_kind_i != 2'b00 && policy_i == 2'b00) |=> !abort_rsp_o);

  // R8: age policy never aborts the requestor
  p_age_keeps_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfl_kind_i != 2'b00 && policy_i == 2'b01) |=> !abort_req_o);

  // R4: equal stamps, lower number wins under age policy
  p_tie_break_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cfl_kind_i != 2'b00 && policy_i == 2'b01 && req_stamp_i == rsp_stamp_i &&
     req_id_i < rsp_id_i) |=> abort_rsp_o);

endmodule

// File: tb/txn_conflict_arbiter_tb_top.sv
module txn_conflict_arbiter_tb_top;

  localparam int NPROC = 8;
  localparam int TS_W  = 16;
  localparam int ID_W  = 3;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [1:0]      cfl_kind;
  logic [1:0]      policy;
  logic [ID_W-1:0] req_id, rsp_id, end_id;
  logic [TS_W-1:0] req_ts, rsp_ts;
  logic            hint, endv;
  logic            stall_o, abort_req_o, abort_rsp_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;
  bit mdl_flag [NPROC];

  always #10 clk = ~clk;

  txn_conflict_arbiter #(.NPROC(NPROC), .TS_W(TS_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfl_kind_i(cfl_kind), .policy_i(policy),
    .req_id_i(req_id), .rsp_id_i(rsp_id), .req_stamp_i(req_ts), .rsp_stamp_i(rsp_ts),
    .dl_hint_i(hint), .txn_end_i(endv), .txn_end_id_i(end_id),
    .stall_o(stall_o), .abort_req_o(abort_req_o), .abort_rsp_o(abort_rsp_o)
  );

  // expected strobes {stall, abort_req, abort_rsp}
  function automatic logic [2:0] expect_act(logic [1:0] k, logic [1:0] p,
      logic [ID_W-1:0] ri, logic [ID_W-1:0] pi, logic [TS_W-1:0] rt,
      logic [TS_W-1:0] pt, logic h);
    logic older, dl;
    older = (rt < pt) || ((rt == pt) && (ri < pi));
    dl    = h || (!older && mdl_flag[ri]);
    if (k == 2'b00) return 3'b000;
    if (p == 2'b01) return older ? 3'b001 : 3'b100;
    if (p == 2'b10 && k == 2'b01 && older) return 3'b001;
    return dl ? 3'b010 : 3'b100;
  endfunction

  task automatic chk(string tag, logic [2:0] exp);
    n_chk++;
    if ({stall_o, abort_req_o, abort_rsp_o} !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b", tag, {stall_o, abort_req_o, abort_rsp_o}, exp);
    end
  endtask

  task automatic apply(string tag, logic [1:0] k, logic [1:0] p,
      logic [ID_W-1:0] ri, logic [ID_W-1:0] pi, logic [TS_W-1:0] rt,
      logic [TS_W-1:0] pt, logic h, logic ev, logic [ID_W-1:0] eid);
    logic [2:0] exp;
    logic older;
    cfl_kind = k; policy = p; req_id = ri; rsp_id = pi;
    req_ts = rt; rsp_ts = pt; hint = h; endv = ev; end_id = eid;
    exp   = expect_act(k, p, ri, pi, rt, pt, h);
    older = (rt < pt) || ((rt == pt) && (ri < pi));
    @(posedge clk);
    @(negedge clk);
    chk(tag, exp);
    if (exp == 3'b100 && older) mdl_flag[pi] = 1'b1;
    if (exp == 3'b010) mdl_flag[ri] = 1'b0;
    if (exp == 3'b001) mdl_flag[pi] = 1'b0;
    if (ev) mdl_flag[eid] = 1'b0;
    cfl_kind = 2'b00; endv = 1'b0; hint = 1'b0;
  endtask

  function automatic string pol_tag(logic [1:0] k, logic [1:0] p);
    if (k == 2'b00) return "R2";
    case (p)
      2'b00:   return "R5";
      2'b01:   return "R8";
      2'b10:   return "R9";
      default: return "R10";
    endcase
  endfunction

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : stim
    int unsigned seed;
    seed = 32'h1bad_5eed;
    void'($urandom(seed));
    for (int i = 0; i < NPROC; i++) mdl_flag[i] = 1'b0;
    cfl_kind = 2'b00; policy = 2'b00; req_id = '0; rsp_id = 3'd1; end_id = '0;
    req_ts = '0; rsp_ts = '0; hint = 1'b0; endv = 1'b0;

    repeat (3) @(negedge clk);
    chk("R1 reset", 3'b000);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after reset", 3'b000);

    // R4 ties resolved by processor number
    apply("R4 tie lower id older", 2'b11, 2'b01, 3'd3, 3'd4, 16'd7, 16'd7, 1'b0, 1'b0, '0);
    apply("R4 tie higher id younger", 2'b11, 2'b01, 3'd4, 3'd3, 16'd7, 16'd7, 1'b0, 1'b0, '0);
    apply("R4 lower stamp older", 2'b10, 2'b01, 3'd6, 3'd1, 16'd2, 16'd9, 1'b0, 1'b0, '0);

    // R6 real deadlock under baseline: 1(old) waits on 2, then 2 asks 1
    apply("R6 old waits", 2'b11, 2'b00, 3'd1, 3'd2, 16'd5, 16'd9, 1'b0, 1'b0, '0);
    apply("R6 deadlock aborts requestor", 2'b10, 2'b00, 3'd2, 3'd1, 16'd9, 16'd5, 1'b0, 1'b0, '0);
    apply("R6 R11 flag cleared by own abort", 2'b10, 2'b00, 3'd2, 3'd1, 16'd9, 16'd5, 1'b0, 1'b0, '0);

    // R11 end report clears; end wins over simultaneous set
    apply("R11 set flag", 2'b11, 2'b00, 3'd0, 3'd5, 16'd1, 16'd8, 1'b0, 1'b0, '0);
    apply("R11 end report", 2'b00, 2'b00, 3'd0, 3'd5, 16'd1, 16'd8, 1'b0, 1'b1, 3'd5);
    apply("R11 flag gone after end", 2'b11, 2'b00, 3'd5, 3'd0, 16'd8, 16'd1, 1'b0, 1'b0, '0);
    apply("R11 end beats set", 2'b11, 2'b10, 3'd0, 3'd6, 16'd1, 16'd8, 1'b0, 1'b1, 3'd6);
    apply("R11 flag clear after race", 2'b01, 2'b00, 3'd6, 3'd0, 16'd8, 16'd1, 1'b0, 1'b0, '0);

    // R9 mixed read/write exception and R11 responder-abort clear
    apply("R9 set flag on 7", 2'b11, 2'b10, 3'd2, 3'd7, 16'd3, 16'd12, 1'b0, 1'b0, '0);
    apply("R9 older writer aborts reader", 2'b01, 2'b10, 3'd2, 3'd7, 16'd3, 16'd12, 1'b0, 1'b0, '0);
    apply("R9 R11 reader flag cleared", 2'b10, 2'b10, 3'd7, 3'd2, 16'd12, 16'd3, 1'b0, 1'b0, '0);

    // R7 hint under baseline and age
    apply("R7 hint aborts baseline requestor", 2'b10, 2'b00, 3'd1, 3'd3, 16'd1, 16'd4, 1'b1, 1'b0, '0);
    apply("R7 hint ignored by age", 2'b10, 2'b01, 3'd3, 3'd1, 16'd4, 16'd1, 1'b1, 1'b0, '0);
    apply("R10 spare acts as baseline", 2'b01, 2'b11, 3'd1, 3'd3, 16'd1, 16'd4, 1'b0, 1'b0, '0);
    apply("R2 no conflict quiet", 2'b00, 2'b01, 3'd1, 3'd3, 16'd1, 16'd4, 1'b1, 1'b0, '0);

    // R3 random mix across all policies
    for (int n = 0; n < 3000; n++) begin
      logic [ID_W-1:0] ri, pi;
      logic [1:0] k, p;
      ri = ID_W'($urandom_range(0, NPROC-1));
      pi = ID_W'((int'(ri) + $urandom_range(1, NPROC-1)) % NPROC);
      k  = 2'($urandom_range(0, 3));
      p  = 2'($urandom_range(0, 3));
      apply({pol_tag(k, p), " R3 random"}, k, p, ri, pi,
            TS_W'($urandom_range(0, 5)), TS_W'($urandom_range(0, 5)),
            ($urandom_range(0, 9) == 0), ($urandom_range(0, 5) == 0),
            ID_W'($urandom_range(0, NPROC-1)));
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule